// File: doc/BRIEF.md
# Root Port Error Message Collector

This block collects error messages arriving at a root port and turns them into a status word, a captured sender identity and an interrupt line. Each message carries a severity (correctable, non-fatal or fatal) and the 16-bit requester ID of the device that sent it. The first message of a class raises that class's received flag and records the sender. A message of the same class that arrives before software acknowledges the first raises a separate multiple-received flag instead. The recorded sender is left as it was.

Software reads the status word and the source word over a small register bus. It acknowledges flags by writing ones to the bits it wants cleared. The interrupt stays high while any received or multiple-received flag is set. A flag that was raised between a software read and the write-back of that read value is therefore still reported.

Top module: `rp_err_collector`

## Requirements
- R1: A valid message with severity code 0 (correctable) sets status bit 0. If bit 0 was clear, the message's requester ID is loaded into bits 15:0 of the source word.
- R2: A correctable message arriving while status bit 0 is already set sets status bit 1. It leaves source bits 15:0 unchanged.
- R3: Severity codes 1 (non-fatal) and 2 (fatal) both set status bit 2, and the ID is loaded into source bits 31:16 when bit 2 was clear. A repeat of either code while bit 2 is set sets bit 3 and keeps the ID.
- R4: A message with severity code 3 changes neither register nor the interrupt.
- R5: A write to address 0 clears exactly those status bits written as one. All other status bits, including a multiple flag set after the value was read, keep their state.
- R6: When a message and a write-one-to-clear of its class's received bit fall in the same cycle, the received bit stays set. The multiple flag is not set, and the new ID is loaded as a fresh first capture.
- R7: The interrupt output is high exactly while any of status bits 3:0 is set, including when only bit 1 or bit 3 remains. It changes in the same clock edge as the status.
- R8: A read returns its data one cycle later with a valid strobe. Address 0 returns the status word with bits 31:4 zero, address 1 returns the source word, and any other address returns zero. Writes to any address other than 0 have no effect.
- R9: A synchronous reset clears the status, the source word and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | An error message is present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 unused |
| msg_rid | input | 16 | Requester ID of the message sender |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (ones clear status bits) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Error interrupt request |

## Verification
Single first messages of each severity show that the correct flag and ID half are loaded. Back-to-back messages of one class show the multiple flag being set while the first ID is held. The key pattern sends a second message between a status read and the write-back of that read value; the residual multiple flag must survive and must keep the interrupt high. Code 3 messages, writes to the source word, a message colliding with its own clear, and unmapped reads each separate the intended behaviour from a plausible wrong one.

// File: rtl/rpec_pkg.sv
package rpec_pkg;
  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_RSVD     = 2'd3
  } sev_e;

  // Status bit positions (software decodes these)
  localparam int ST_COR  = 0;
  localparam int ST_MCOR = 1;
  localparam int ST_UNC  = 2;
  localparam int ST_MUNC = 3;
  localparam int ST_W    = 4;

  // Number of message classes (correctable, uncorrectable)
  localparam int N_CLASS = 2;
endpackage

// File: rtl/rpec_flag_pair.sv
// One message class: first-received flag, multiple-received flag, source ID.
module rpec_flag_pair #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hit_i,
  input  logic [ID_W-1:0] rid_i,
  input  logic            clr_first_i,
  input  logic            clr_multi_i,
  output logic            first_o,
  output logic            multi_o,
  output logic            pend_nx_o,
  output logic [ID_W-1:0] id_o
);
  logic            first_q, multi_q;
  logic            first_nx, multi_nx, cap;
  logic [ID_W-1:0] id_q;

  always_comb begin
    first_nx = first_q;
    multi_nx = multi_q;
    cap      = 1'b0;
    if (clr_first_i) first_nx = 1'b0;
    if (clr_multi_i) multi_nx = 1'b0;
    if (hit_i) begin
      first_nx = 1'b1;
      if (first_q && !clr_first_i) multi_nx = 1'b1;
      else                         cap      = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b0;
      multi_q <= 1'b0;
      id_q    <= '0;
    end else begin
      first_q <= first_nx;
      multi_q <= multi_nx;
      if (cap) id_q <= rid_i;
    end
  end

  assign first_o   = first_q;
  assign multi_o   = multi_q;
  assign id_o      = id_q;
  assign pend_nx_o = first_nx | multi_nx;

  a_r1_first_capture: assert property (@(posedge clk) disable iff (rst)
    hit_i && !first_q |=> first_q && (id_q == $past(rid_i)));
  a_r2_repeat_keeps_id: assert property (@(posedge clk) disable iff (rst)
    hit_i && first_q && !clr_first_i |=> multi_q && $stable(id_q));
  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    hit_i && clr_first_i |=> first_q && (id_q == $past(rid_i)));
  a_r5_clear_applies: assert property (@(posedge clk) disable iff (rst)
    clr_first_i && !hit_i |=> !first_q);
  a_r5_untouched_holds: assert property (@(posedge clk) disable iff (rst)
    !clr_multi_i && !hit_i |=> multi_q == $past(multi_q));
endmodule

// File: rtl/rpec_irq.sv
// Registered interrupt from the OR of the next-state pending terms.
module rpec_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_nx_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_nx_i;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/rpec_rdport.sv
// Registered read mux with one-cycle latency.
module rpec_rdport #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] A_STAT = '0,
  parameter logic [ADDR_W-1:0] A_SRC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [DATA_W-1:0] rdata_q, mux;
  logic              rvalid_q;

  always_comb begin
    unique case (addr_i)
      A_STAT:  mux = stat_i;
      A_SRC:   mux = src_i;
      default: mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      rdata_q  <= rd_i ? mux : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  a_r8_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> rvalid_q);
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rvalid_q |-> rdata_q == '0);
endmodule

// File: rtl/rp_err_collector.sv
module rp_err_collector
  import rpec_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int ID_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                msg_valid,
  input  logic [1:0]          msg_sev,
  input  logic [ID_W-1:0]     msg_rid,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [2*ID_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [2*ID_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic                irq
);
  localparam int DATA_W = 2 * ID_W;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(1);

  sev_e sev;
  logic [ST_W-1:0]    clr;
  logic [N_CLASS-1:0] hit, first, multi, pend_nx;
  logic [ID_W-1:0]    id [N_CLASS];
  logic [DATA_W-1:0]  stat_w, src_w;

  assign sev = sev_e'(msg_sev);
  assign clr = (bus_wr && bus_addr == A_STAT) ? ST_W'(bus_wdata) : '0;

  assign hit[0] = msg_valid && (sev == SEV_COR);
  assign hit[1] = msg_valid && (sev == SEV_NONFATAL || sev == SEV_FATAL);

  for (genvar c = 0; c < N_CLASS; c++) begin : g_class
    rpec_flag_pair #(.ID_W(ID_W)) u_flags (
      .clk         (clk),
      .rst         (rst),
      .hit_i       (hit[c]),
      .rid_i       (msg_rid),
      .clr_first_i (clr[2*c]),
      .clr_multi_i (clr[2*c+1]),
      .first_o     (first[c]),
      .multi_o     (multi[c]),
      .pend_nx_o   (pend_nx[c]),
      .id_o        (id[c])
    );
  end

  always_comb begin
    stat_w          = '0;
    stat_w[ST_COR]  = first[0];
    stat_w[ST_MCOR] = multi[0];
    stat_w[ST_UNC]  = first[1];
    stat_w[ST_MUNC] = multi[1];
  end
  assign src_w = {id[1], id[0]};

  rpec_irq #(.N(N_CLASS)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .pend_nx_i (pend_nx),
    .irq_o     (irq)
  );

  rpec_rdport #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .A_STAT (A_STAT),
    .A_SRC  (A_SRC)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_i     (bus_rd),
    .addr_i   (bus_addr),
    .stat_i   (stat_w),
    .src_i    (src_w),
    .rdata_o  (bus_rdata),
    .rvalid_o (bus_rvalid)
  );

  a_r7_irq_tracks_status: assert property (@(posedge clk) disable iff (rst)
    irq == (|{first, multi}));
  a_r4_rsvd_no_change: assert property (@(posedge clk) disable iff (rst)
    msg_valid && sev == SEV_RSVD && !bus_wr |=> $stable(first) && $stable(multi));
endmodule

// File: tb/test_rp_err_collector.sv
module test_rp_err_collector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_sev = 2'd0;
  logic [15:0] msg_rid = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rp_err_collector i_rp_err_collector (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_rid(msg_rid), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever read data comes back
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected rvalid", 32'd1, 32'd0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic send_msg(input logic [1:0] sev, input logic [15:0] rid);
    @(negedge clk);
    msg_valid = 1'b1; msg_sev = sev; msg_rid = rid;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic collide(input logic [1:0] sev, input logic [15:0] rid,
                         input logic [31:0] d);
    @(negedge clk);
    msg_valid = 1'b1; msg_sev = sev; msg_rid = rid;
    bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = d;
    @(negedge clk);
    msg_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    check(irq === e, t, {31'd0, irq}, {31'd0, e});
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, "R9 irq after reset");
    rd(4'd0, 32'h0, "R9 status after reset");
    rd(4'd1, 32'h0, "R9 source after reset");

    // First correctable message
    send_msg(2'd0, 16'hA11C);
    chk_irq(1'b1, "R7 irq on first correctable");
    rd(4'd0, 32'h1, "R1 status bit0");
    rd(4'd1, 32'h0000_A11C, "R1 source low half");

    // Second message arrives after software has read 0x1
    send_msg(2'd0, 16'hB22D);
    rd(4'd0, 32'h3, "R2 multiple correctable set");
    rd(4'd1, 32'h0000_A11C, "R2 source unchanged");

    // Write back the stale read value: multiple flag survives
    wr(4'd0, 32'h1);
    rd(4'd0, 32'h2, "R5 stale write-back leaves bit1");
    chk_irq(1'b1, "R7 irq with only multiple flag");
    wr(4'd0, 32'h2);
    rd(4'd0, 32'h0, "R5 bit1 cleared");
    chk_irq(1'b0, "R7 irq low when clear");

    // Reserved severity
    send_msg(2'd3, 16'hDEAD);
    chk_irq(1'b0, "R4 irq after code 3");
    rd(4'd0, 32'h0, "R4 status after code 3");
    rd(4'd1, 32'h0000_A11C, "R4 source after code 3");

    // Uncorrectable class
    send_msg(2'd1, 16'h0105);
    rd(4'd0, 32'h4, "R3 non-fatal sets bit2");
    rd(4'd1, 32'h0105_A11C, "R3 source high half");
    send_msg(2'd2, 16'h0207);
    rd(4'd0, 32'hC, "R3 fatal repeat sets bit3");
    rd(4'd1, 32'h0105_A11C, "R3 source kept on repeat");

    // Writes elsewhere ignored; partial clear
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h0105_A11C, "R8 source write ignored");
    rd(4'd0, 32'hC, "R8 status after source write");
    wr(4'd0, 32'hFFFF_FFF8);
    rd(4'd0, 32'h4, "R5 clears only bit3");
    chk_irq(1'b1, "R7 irq with bit2");

    // Collision: set wins, fresh capture
    send_msg(2'd0, 16'h0C01);
    rd(4'd0, 32'h5, "R1 correctable again");
    collide(2'd0, 16'h0C02, 32'h1);
    rd(4'd0, 32'h5, "R6 set beats clear, no multiple");
    rd(4'd1, 32'h0105_0C02, "R6 fresh capture on collision");

    rd(4'd5, 32'h0, "R8 unmapped read zero");

    wr(4'd0, 32'hF);
    chk_irq(1'b0, "R7 irq low after full clear");
    send_msg(2'd0, 16'h0C03);
    rd(4'd1, 32'h0105_0C03, "R1 reload after clear");

    // Reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_irq(1'b0, "R9 irq after second reset");
    rd(4'd1, 32'h0, "R9 source after second reset");

    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R8 all reads answered",
          32'(exp_q.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule